// File: doc/BRIEF.md
# Banked UART Register Access Decoder

This block is the host-side register file and address decoder of a 16550-style UART. The host sees only eight addresses, through a 3-bit address, a chip select and separate read and write strobes. Behind that window sit more than eight physical registers. The decoder picks one of them from the address and from the state of the line control register, a one-cycle enhanced-bank flag and the additional control register. It owns the line control, the 16-bit divisor, the interrupt enable, the modem control and the scratch/offset byte. It also owns an enhanced feature byte, four flow-control character bytes and a small indexed control array. Entry 0 of that array is the additional control register.

The serial engine, the FIFOs, the baud generator and the interrupt logic are outside the block. Their status bytes come in as plain inputs. The block gives them single-cycle push, pop and FIFO-control strobes and the live contents of its control registers. Every host access is sampled at a rising clock edge. Read data and strobes appear registered one cycle later.

Top module: `uart_regbank_decoder`

## Requirements
- R1: After reset, line control, divisor, interrupt enable, modem control, enhanced feature, scratch/offset, the indexed array, rdata and all strobes are 0. The default map is therefore in force.
- R2: Default map. Address 1 holds interrupt enable, 3 line control, 4 modem control and 7 scratch/offset. Each can be written and read back. Reading 5 (with indexed reads off) returns lsr_in, and reading 6 returns msr_in.
- R3: With line_ctrl[7]=1 and the enhanced bank off, address 0 reaches divisor bits 7:0 and address 1 reaches bits 15:8. Neither address raises tx_push or rx_pop.
- R4: Writing 0xBF to address 3 selects the enhanced bank. It sets line_ctrl[7] and keeps line_ctrl[6:0] unchanged.
- R5: In the enhanced bank, address 2 reaches the enhanced feature byte and addresses 4, 5, 6 and 7 reach flow-control characters 0 to 3. Addresses 0 and 1 still reach the divisor bytes, and address 3 reaches line control. No access in this bank raises tx_push, rx_pop or fifo_ctrl_we.
- R6: Writing any value other than 0xBF to address 3 stores that value whole into line control and leaves the enhanced bank.
- R7: In the default map, a write to address 0 raises tx_push for exactly the next cycle, with tx_data equal to the written byte. A read of address 0 raises rx_pop for the next cycle and returns rx_data_in.
- R8: In the default map, a write to address 2 raises fifo_ctrl_we for one cycle, with fifo_ctrl equal to the written byte. A read of address 2 returns isr_in.
- R9: Outside the enhanced bank, a write to address 5 stores the byte into the indexed array at the entry named by the scratch/offset register. Entry 0 is the additional control register.
- R10: When additional-control bit 6 is 1, a read of address 5 outside the enhanced bank returns the indexed entry. When that bit is 0, the read returns lsr_in.
- R11: Indexed entries at offsets 1 and above take writes only while additional-control bit 7 is 1, and read as 0 while it is 0. Entry 0 is always accessible.
- R12: An offset of ICR_DEPTH (8) or more makes an indexed write do nothing and an indexed read return 0.
- R13: rdata changes only in the cycle after a read. A cycle with both rd_en and wr_en counts as a write only: no rx_pop and no change to rdata.
- R14: Writes to address 6 in the default map change no register and raise no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs | input | 1 | Chip select |
| wr_en | input | 1 | Write strobe, sampled with cs |
| rd_en | input | 1 | Read strobe, sampled with cs |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| rx_data_in | input | 8 | Head byte of the receive FIFO |
| isr_in | input | 8 | Interrupt status from the interrupt logic |
| lsr_in | input | 8 | Line status from the serial engine |
| msr_in | input | 8 | Modem status from the serial engine |
| tx_push | output | 1 | One-cycle push strobe to the transmit FIFO |
| tx_data | output | 8 | Byte for the transmit FIFO |
| rx_pop | output | 1 | One-cycle pop strobe to the receive FIFO |
| fifo_ctrl_we | output | 1 | One-cycle FIFO control write strobe |
| fifo_ctrl | output | 8 | Last FIFO control byte written |
| line_ctrl | output | 8 | Line control register |
| divisor | output | 16 | Baud divisor |
| int_en | output | 8 | Interrupt enable register |
| modem_ctrl | output | 8 | Modem control register |
| enh_feat | output | 8 | Enhanced feature register |

## Verification
A stale bank flag or a corrupted line control byte shows up at once. The very next access to address 0, 1 or 2 lands on the wrong register, so a stray tx_push, rx_pop or fifo_ctrl_we appears, or rdata carries the wrong byte, one cycle after that access. A wrong offset or wrong additional-control bits surface as a wrong value on the first read of address 5. An indexed write that went to the wrong entry stays invisible until that entry is read back. The bench therefore keeps a full model of every register and reads registers back often, so that a bad write is caught within a few accesses.

// File: rtl/uart_rb_pkg.sv
package uart_rb_pkg;

  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;
  localparam int FC_NUM = 4;
  localparam logic [DATA_W-1:0] ENH_KEY = 8'hBF;

  typedef enum logic [4:0] {
    SEL_NONE,
    SEL_THR,
    SEL_RHR,
    SEL_DLL,
    SEL_DLM,
    SEL_IER,
    SEL_FCR,
    SEL_ISR,
    SEL_LCR,
    SEL_MCR,
    SEL_LSR,
    SEL_ICR,
    SEL_MSR,
    SEL_SPR,
    SEL_EFR,
    SEL_FC0,
    SEL_FC1,
    SEL_FC2,
    SEL_FC3
  } reg_sel_e;

  typedef struct packed {
    reg_sel_e sel;
    logic     wr;
    logic     rd;
  } access_t;

endpackage

// File: rtl/uart_rb_decode.sv
module uart_rb_decode
  import uart_rb_pkg::*;
(
  input  logic              cs,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              enh_sel,
  input  logic              dlab,
  input  logic              idx_rd_en,
  output access_t           acc
);

  logic     wr_hit;
  logic     rd_hit;
  reg_sel_e sel_enh;
  reg_sel_e sel_std;

  // a cycle with both strobes is a write only
  assign wr_hit = cs & wr_en;
  assign rd_hit = cs & rd_en & ~wr_en;

  always_comb begin
    unique case (addr)
      3'd0:    sel_enh = SEL_DLL;
      3'd1:    sel_enh = SEL_DLM;
      3'd2:    sel_enh = SEL_EFR;
      3'd3:    sel_enh = SEL_LCR;
      3'd4:    sel_enh = SEL_FC0;
      3'd5:    sel_enh = SEL_FC1;
      3'd6:    sel_enh = SEL_FC2;
      default: sel_enh = SEL_FC3;
    endcase
  end

  always_comb begin
    unique case (addr)
      3'd0:    sel_std = dlab ? SEL_DLL : (wr_hit ? SEL_THR : SEL_RHR);
      3'd1:    sel_std = dlab ? SEL_DLM : SEL_IER;
      3'd2:    sel_std = wr_hit ? SEL_FCR : SEL_ISR;
      3'd3:    sel_std = SEL_LCR;
      3'd4:    sel_std = SEL_MCR;
      3'd5:    sel_std = (wr_hit || idx_rd_en) ? SEL_ICR : SEL_LSR;
      3'd6:    sel_std = SEL_MSR;
      default: sel_std = SEL_SPR;
    endcase
  end

  always_comb begin
    acc.wr  = wr_hit;
    acc.rd  = rd_hit;
    acc.sel = SEL_NONE;
    if (wr_hit || rd_hit) begin
      acc.sel = enh_sel ? sel_enh : sel_std;
    end
  end

endmodule

// File: rtl/uart_rb_ctrl_regs.sv
module uart_rb_ctrl_regs
  import uart_rb_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  reg_sel_e                      sel,
  input  logic                          wr,
  input  logic [DATA_W-1:0]             wdata,
  output logic [DATA_W-1:0]             lcr_q,
  output logic                          enh_q,
  output logic [DATA_W-1:0]             dll_q,
  output logic [DATA_W-1:0]             dlm_q,
  output logic [DATA_W-1:0]             ier_q,
  output logic [DATA_W-1:0]             mcr_q,
  output logic [DATA_W-1:0]             spr_q,
  output logic [DATA_W-1:0]             efr_q,
  output logic [FC_NUM-1:0][DATA_W-1:0] fc_q
);

  logic [DATA_W-1:0]             lcr_d;
  logic                          enh_d;
  logic [DATA_W-1:0]             dll_d;
  logic [DATA_W-1:0]             dlm_d;
  logic [DATA_W-1:0]             ier_d;
  logic [DATA_W-1:0]             mcr_d;
  logic [DATA_W-1:0]             spr_d;
  logic [DATA_W-1:0]             efr_d;
  logic [FC_NUM-1:0][DATA_W-1:0] fc_d;

  always_comb begin
    lcr_d = lcr_q;
    enh_d = enh_q;
    dll_d = dll_q;
    dlm_d = dlm_q;
    ier_d = ier_q;
    mcr_d = mcr_q;
    spr_d = spr_q;
    efr_d = efr_q;
    fc_d  = fc_q;
    case (sel)
      SEL_LCR: begin
        if (wdata == ENH_KEY) begin
          lcr_d = {1'b1, lcr_q[DATA_W-2:0]};
          enh_d = 1'b1;
        end else begin
          lcr_d = wdata;
          enh_d = 1'b0;
        end
      end
      SEL_DLL: dll_d   = wdata;
      SEL_DLM: dlm_d   = wdata;
      SEL_IER: ier_d   = wdata;
      SEL_MCR: mcr_d   = wdata;
      SEL_SPR: spr_d   = wdata;
      SEL_EFR: efr_d   = wdata;
      SEL_FC0: fc_d[0] = wdata;
      SEL_FC1: fc_d[1] = wdata;
      SEL_FC2: fc_d[2] = wdata;
      SEL_FC3: fc_d[3] = wdata;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcr_q <= '0;
      enh_q <= 1'b0;
      dll_q <= '0;
      dlm_q <= '0;
      ier_q <= '0;
      mcr_q <= '0;
      spr_q <= '0;
      efr_q <= '0;
      fc_q  <= '0;
    end else if (wr) begin
      lcr_q <= lcr_d;
      enh_q <= enh_d;
      dll_q <= dll_d;
      dlm_q <= dlm_d;
      ier_q <= ier_d;
      mcr_q <= mcr_d;
      spr_q <= spr_d;
      efr_q <= efr_d;
      fc_q  <= fc_d;
    end
  end

endmodule

// File: rtl/uart_rb_icr.sv
module uart_rb_icr
  import uart_rb_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] ptr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              idx_rd_en
);

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0][DATA_W-1:0] mem_q;
  logic [DEPTH-1:0]             hit_vec;
  logic [DEPTH-1:0]             we_vec;
  logic                         in_range;
  logic                         ext_en;
  logic [IDX_W-1:0]             idx;

  assign in_range  = (32'(ptr) < DEPTH);
  assign idx       = ptr[IDX_W-1:0];
  assign ext_en    = mem_q[0][7];
  assign idx_rd_en = mem_q[0][6];

  for (genvar k = 0; k < DEPTH; k++) begin : g_ent
    localparam bit IS_EXT = (k != 0);
    assign hit_vec[k] = in_range && (idx == IDX_W'(k)) && (!IS_EXT || ext_en);
    assign we_vec[k]  = we && hit_vec[k];
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (hit_vec[k]) rdata = rdata | mem_q[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
    end else begin
      for (int k = 0; k < DEPTH; k++) begin
        if (we_vec[k]) mem_q[k] <= wdata;
      end
    end
  end

endmodule

// File: rtl/uart_regbank_decoder.sv
module uart_regbank_decoder
  import uart_rb_pkg::*;
#(
  parameter int ICR_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [2:0]        addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic [7:0]        rx_data_in,
  input  logic [7:0]        isr_in,
  input  logic [7:0]        lsr_in,
  input  logic [7:0]        msr_in,
  output logic              tx_push,
  output logic [7:0]        tx_data,
  output logic              rx_pop,
  output logic              fifo_ctrl_we,
  output logic [7:0]        fifo_ctrl,
  output logic [7:0]        line_ctrl,
  output logic [15:0]       divisor,
  output logic [7:0]        int_en,
  output logic [7:0]        modem_ctrl,
  output logic [7:0]        enh_feat
);

  logic [1:0]                    rst_sync_q;
  logic                          rst_sync_n;
  access_t                       acc;
  logic [DATA_W-1:0]             lcr_q;
  logic                          enh_sel;
  logic [DATA_W-1:0]             dll_q;
  logic [DATA_W-1:0]             dlm_q;
  logic [DATA_W-1:0]             ier_q;
  logic [DATA_W-1:0]             mcr_q;
  logic [DATA_W-1:0]             spr_q;
  logic [DATA_W-1:0]             efr_q;
  logic [FC_NUM-1:0][DATA_W-1:0] fc_q;
  logic [DATA_W-1:0]             icr_rdata;
  logic                          idx_rd_en;
  logic                          icr_we;
  logic [DATA_W-1:0]             rd_mux;
  logic [DATA_W-1:0]             rdata_q;
  logic                          tx_push_q;
  logic [DATA_W-1:0]             tx_data_q;
  logic                          rx_pop_q;
  logic                          fcr_we_q;
  logic [DATA_W-1:0]             fcr_q;

  // reset asserts at once and is released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  uart_rb_decode u_decode (
    .cs        (cs),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .enh_sel   (enh_sel),
    .dlab      (lcr_q[7]),
    .idx_rd_en (idx_rd_en),
    .acc       (acc)
  );

  uart_rb_ctrl_regs u_regs (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .sel   (acc.sel),
    .wr    (acc.wr),
    .wdata (wdata),
    .lcr_q (lcr_q),
    .enh_q (enh_sel),
    .dll_q (dll_q),
    .dlm_q (dlm_q),
    .ier_q (ier_q),
    .mcr_q (mcr_q),
    .spr_q (spr_q),
    .efr_q (efr_q),
    .fc_q  (fc_q)
  );

  assign icr_we = acc.wr && (acc.sel == SEL_ICR);

  uart_rb_icr #(.DEPTH(ICR_DEPTH)) u_icr (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .we        (icr_we),
    .ptr       (spr_q),
    .wdata     (wdata),
    .rdata     (icr_rdata),
    .idx_rd_en (idx_rd_en)
  );

  always_comb begin
    case (acc.sel)
      SEL_RHR: rd_mux = rx_data_in;
      SEL_DLL: rd_mux = dll_q;
      SEL_DLM: rd_mux = dlm_q;
      SEL_IER: rd_mux = ier_q;
      SEL_ISR: rd_mux = isr_in;
      SEL_LCR: rd_mux = lcr_q;
      SEL_MCR: rd_mux = mcr_q;
      SEL_LSR: rd_mux = lsr_in;
      SEL_ICR: rd_mux = icr_rdata;
      SEL_MSR: rd_mux = msr_in;
      SEL_SPR: rd_mux = spr_q;
      SEL_EFR: rd_mux = efr_q;
      SEL_FC0: rd_mux = fc_q[0];
      SEL_FC1: rd_mux = fc_q[1];
      SEL_FC2: rd_mux = fc_q[2];
      SEL_FC3: rd_mux = fc_q[3];
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rdata_q   <= '0;
      tx_push_q <= 1'b0;
      tx_data_q <= '0;
      rx_pop_q  <= 1'b0;
      fcr_we_q  <= 1'b0;
      fcr_q     <= '0;
    end else begin
      tx_push_q <= acc.wr && (acc.sel == SEL_THR);
      rx_pop_q  <= acc.rd && (acc.sel == SEL_RHR);
      fcr_we_q  <= acc.wr && (acc.sel == SEL_FCR);
      if (acc.rd) rdata_q <= rd_mux;
      if (acc.wr && (acc.sel == SEL_THR)) tx_data_q <= wdata;
      if (acc.wr && (acc.sel == SEL_FCR)) fcr_q <= wdata;
    end
  end

  assign rdata        = rdata_q;
  assign tx_push      = tx_push_q;
  assign tx_data      = tx_data_q;
  assign rx_pop       = rx_pop_q;
  assign fifo_ctrl_we = fcr_we_q;
  assign fifo_ctrl    = fcr_q;
  assign line_ctrl    = lcr_q;
  assign divisor      = {dlm_q, dll_q};
  assign int_en       = ier_q;
  assign modem_ctrl   = mcr_q;
  assign enh_feat     = efr_q;

endmodule

// File: rtl/uart_rb_checker.sv
module uart_rb_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cs,
  input logic        wr_en,
  input logic        rd_en,
  input logic [2:0]  addr,
  input logic [7:0]  wdata,
  input logic [7:0]  rdata,
  input logic        enh_sel,
  input logic        tx_push,
  input logic        rx_pop,
  input logic        fifo_ctrl_we,
  input logic [7:0]  line_ctrl,
  input logic [15:0] divisor,
  input logic [7:0]  enh_feat
);

  AST_PUSH_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push |-> $past(cs && wr_en && addr == 3'd0 && !line_ctrl[7])); // R7

  AST_POP_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |-> $past(cs && rd_en && !wr_en && addr == 3'd0 && !line_ctrl[7])); // R7

  AST_DIV_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && addr == 3'd0 && line_ctrl[7]) |=> (!tx_push && !rx_pop)); // R3

  AST_DIV_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr_en && addr == 3'd0 && line_ctrl[7]) |=> (divisor[7:0] == $past(wdata))); // R3

  AST_KEY_KEEPS_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr_en && addr == 3'd3 && wdata == 8'hBF)
      |=> (line_ctrl == {1'b1, $past(line_ctrl[6:0])} && enh_sel)); // R4

  AST_EFR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr_en && addr == 3'd2 && enh_sel) |=> (enh_feat == $past(wdata) && !fifo_ctrl_we)); // R5

  AST_LCR_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr_en && addr == 3'd3 && wdata != 8'hBF) |=> (line_ctrl == $past(wdata) && !enh_sel)); // R6

  AST_FCR_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_ctrl_we |-> $past(cs && wr_en && addr == 3'd2 && !enh_sel)); // R8

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs && rd_en && !wr_en) |=> $stable(rdata)); // R13

endmodule

bind uart_regbank_decoder uart_rb_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .cs           (cs),
  .wr_en        (wr_en),
  .rd_en        (rd_en),
  .addr         (addr),
  .wdata        (wdata),
  .rdata        (rdata),
  .enh_sel      (enh_sel),
  .tx_push      (tx_push),
  .rx_pop       (rx_pop),
  .fifo_ctrl_we (fifo_ctrl_we),
  .line_ctrl    (line_ctrl),
  .divisor      (divisor),
  .enh_feat     (enh_feat)
);

// File: tb/tb_uart_regbank_decoder.sv
`timescale 1ns/1ps
module tb_uart_regbank_decoder;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs, wr_en, rd_en;
  logic [2:0]  addr;
  logic [7:0]  wdata, rdata;
  logic [7:0]  rx_data_in, isr_in, lsr_in, msr_in;
  logic        tx_push, rx_pop, fifo_ctrl_we;
  logic [7:0]  tx_data, fifo_ctrl, line_ctrl, int_en, modem_ctrl, enh_feat;
  logic [15:0] divisor;

  always #4 clk = ~clk;

  uart_regbank_decoder dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rx_data_in(rx_data_in),
    .isr_in(isr_in), .lsr_in(lsr_in), .msr_in(msr_in), .tx_push(tx_push),
    .tx_data(tx_data), .rx_pop(rx_pop), .fifo_ctrl_we(fifo_ctrl_we),
    .fifo_ctrl(fifo_ctrl), .line_ctrl(line_ctrl), .divisor(divisor),
    .int_en(int_en), .modem_ctrl(modem_ctrl), .enh_feat(enh_feat)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench model of the register file
  logic [7:0] m_lcr, m_dll, m_dlm, m_ier, m_mcr, m_spr, m_efr, m_fifo, m_txd, m_rd;
  bit         m_enh;
  logic [7:0] m_fc [4];
  logic [7:0] m_icr [8];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit icr_ok();
    return (m_spr < 8) && (m_spr == 0 || m_icr[0][7]);
  endfunction

  function automatic logic [7:0] exp_read(input logic [2:0] a);
    if (m_enh) begin
      case (a)
        3'd0: return m_dll;
        3'd1: return m_dlm;
        3'd2: return m_efr;
        3'd3: return m_lcr;
        default: return m_fc[a[1:0]];
      endcase
    end
    if (m_lcr[7] && a < 2) return (a == 0) ? m_dll : m_dlm;
    case (a)
      3'd0: return rx_data_in;
      3'd1: return m_ier;
      3'd2: return isr_in;
      3'd3: return m_lcr;
      3'd4: return m_mcr;
      3'd5: return m_icr[0][6] ? (icr_ok() ? m_icr[m_spr[2:0]] : 8'h00) : lsr_in;
      3'd6: return msr_in;
      default: return m_spr;
    endcase
  endfunction

  function automatic string rand_tag(input logic [2:0] a);
    if (m_enh) return "R5";
    if (m_lcr[7] && a < 2) return "R3";
    if (a == 0) return "R7";
    if (a == 2) return "R8";
    if (a == 3) return "R6";
    if (a == 5) return "R9";
    if (a == 6) return "R14";
    return "R2";
  endfunction

  task automatic drive_status();
    rx_data_in = 8'($urandom);
    isr_in     = 8'($urandom);
    lsr_in     = 8'($urandom);
    msr_in     = 8'($urandom);
  endtask

  task automatic lcr_model(input logic [7:0] d);
    if (d == 8'hBF) begin
      m_lcr[7] = 1'b1;
      m_enh    = 1'b1;
    end else begin
      m_lcr = d;
      m_enh = 1'b0;
    end
  endtask

  task automatic do_write(input logic [2:0] a, input logic [7:0] d, input string tag,
                          input bit also_rd = 1'b0);
    bit ep, ef;
    @(negedge clk);
    drive_status();
    cs = 1'b1; wr_en = 1'b1; rd_en = also_rd; addr = a; wdata = d;
    ep = 1'b0; ef = 1'b0;
    if (m_enh) begin
      case (a)
        3'd0: m_dll = d;
        3'd1: m_dlm = d;
        3'd2: m_efr = d;
        3'd3: lcr_model(d);
        default: m_fc[a[1:0]] = d;
      endcase
    end else if (m_lcr[7] && a < 2) begin
      if (a == 0) m_dll = d; else m_dlm = d;
    end else begin
      case (a)
        3'd0: begin ep = 1'b1; m_txd = d; end
        3'd1: m_ier = d;
        3'd2: begin ef = 1'b1; m_fifo = d; end
        3'd3: lcr_model(d);
        3'd4: m_mcr = d;
        3'd5: if (icr_ok()) m_icr[m_spr[2:0]] = d;
        3'd6: ;
        default: m_spr = d;
      endcase
    end
    @(negedge clk);
    cs = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    chk({tag, " tx_push"}, tx_push, ep);
    chk({tag, " tx_data"}, tx_data, m_txd);
    chk({tag, " rx_pop"}, rx_pop, 0);
    chk({tag, " fifo_ctrl_we"}, fifo_ctrl_we, ef);
    chk({tag, " fifo_ctrl"}, fifo_ctrl, m_fifo);
    chk({tag, " line_ctrl"}, line_ctrl, m_lcr);
    chk({tag, " divisor"}, divisor, {m_dlm, m_dll});
    chk({tag, " int_en"}, int_en, m_ier);
    chk({tag, " modem_ctrl"}, modem_ctrl, m_mcr);
    chk({tag, " enh_feat"}, enh_feat, m_efr);
    chk({tag, " rdata held"}, rdata, m_rd);
  endtask

  task automatic do_read(input logic [2:0] a, input string tag);
    bit ep;
    @(negedge clk);
    drive_status();
    cs = 1'b1; rd_en = 1'b1; wr_en = 1'b0; addr = a;
    m_rd = exp_read(a);
    ep = (a == 0) && !m_enh && !m_lcr[7];
    @(negedge clk);
    cs = 1'b0; rd_en = 1'b0;
    chk({tag, " rdata"}, rdata, m_rd);
    chk({tag, " rx_pop"}, rx_pop, ep);
    chk({tag, " tx_push"}, tx_push, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1F2E_3D4C));
    cs = 0; wr_en = 0; rd_en = 0; addr = 0; wdata = 0;
    rx_data_in = 0; isr_in = 0; lsr_in = 0; msr_in = 0;
    m_lcr = 0; m_dll = 0; m_dlm = 0; m_ier = 0; m_mcr = 0; m_spr = 0;
    m_efr = 0; m_fifo = 0; m_txd = 0; m_rd = 0; m_enh = 0;
    for (int i = 0; i < 4; i++) m_fc[i] = 0;
    for (int i = 0; i < 8; i++) m_icr[i] = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 rdata", rdata, 0);
    chk("R1 line_ctrl", line_ctrl, 0);
    chk("R1 divisor", divisor, 0);
    chk("R1 strobes", {tx_push, rx_pop, fifo_ctrl_we}, 0);
    chk("R1 enh_feat", enh_feat, 0);
    do_read(3'd3, "R1");
    do_read(3'd7, "R1");
    do_read(3'd0, "R1");

    // R2 default map
    do_write(3'd7, 8'h5A, "R2");
    do_read(3'd7, "R2");
    do_write(3'd1, 8'h0F, "R2");
    do_write(3'd4, 8'h13, "R2");
    do_read(3'd1, "R2");
    do_read(3'd4, "R2");
    do_read(3'd5, "R2");
    do_read(3'd6, "R2");

    // R14 write to status address ignored
    do_write(3'd6, 8'hFF, "R14");
    do_read(3'd6, "R14");

    // R7 push and pop strobes
    do_write(3'd0, 8'h33, "R7");
    @(negedge clk);
    chk("R7 tx_push single cycle", tx_push, 0);
    do_read(3'd0, "R7");
    @(negedge clk);
    chk("R7 rx_pop single cycle", rx_pop, 0);

    // R8 FIFO control and interrupt status
    do_write(3'd2, 8'hC1, "R8");
    @(negedge clk);
    chk("R8 fifo_ctrl_we single cycle", fifo_ctrl_we, 0);
    do_read(3'd2, "R8");

    // R3 divisor bank
    do_write(3'd3, 8'h83, "R3");
    do_write(3'd0, 8'h12, "R3");
    do_write(3'd1, 8'h34, "R3");
    chk("R3 divisor value", divisor, 16'h3412);
    do_read(3'd0, "R3");
    do_read(3'd1, "R3");

    // R4 key write keeps format bits
    do_write(3'd3, 8'h1B, "R4");
    do_write(3'd3, 8'hBF, "R4");
    chk("R4 line_ctrl after key", line_ctrl, 8'h9B);

    // R5 enhanced bank map
    do_write(3'd2, 8'hA5, "R5");
    for (int i = 4; i < 8; i++) do_write(3'(i), 8'(8'h60 + i), "R5");
    for (int i = 0; i < 8; i++) do_read(3'(i), "R5");
    do_write(3'd0, 8'h77, "R5");

    // R6 leave enhanced bank
    do_write(3'd3, 8'h03, "R6");
    chk("R6 line_ctrl exit", line_ctrl, 8'h03);
    do_read(3'd2, "R6");
    do_read(3'd4, "R6");
    do_read(3'd0, "R6");

    // R9 R10 indexed access through offset
    do_write(3'd7, 8'h00, "R9");
    do_write(3'd5, 8'h40, "R9");
    do_read(3'd5, "R10");
    // R11 extended entries gated by bit 7
    do_write(3'd7, 8'h03, "R11");
    do_write(3'd5, 8'h77, "R11");
    do_read(3'd5, "R11");
    do_write(3'd7, 8'h00, "R11");
    do_write(3'd5, 8'hC0, "R11");
    do_write(3'd7, 8'h03, "R11");
    do_write(3'd5, 8'h77, "R11");
    do_read(3'd5, "R11");
    // R12 offset out of range
    do_write(3'd7, 8'h09, "R12");
    do_write(3'd5, 8'h11, "R12");
    do_read(3'd5, "R12");
    // R10 indexed reads off
    do_write(3'd7, 8'h00, "R10");
    do_write(3'd5, 8'h80, "R10");
    do_read(3'd5, "R10");

    // R13 simultaneous strobes and read data hold
    do_read(3'd7, "R13");
    do_write(3'd0, 8'h99, "R13", 1'b1);
    repeat (3) @(negedge clk);
    chk("R13 rdata idle hold", rdata, m_rd);

    // constrained random mix
    for (int n = 0; n < 400; n++) begin
      logic [2:0] a;
      logic [7:0] d;
      int         r;
      a = 3'($urandom);
      d = 8'($urandom);
      r = int'($urandom % 10);
      if (a == 3) begin
        if (r < 3) d = 8'hBF;
        else if (r < 6) d[7] = 1'b0;
      end
      if (a == 7 && r < 8) d = 8'($urandom % 10);
      if (($urandom % 2) == 0) do_read(a, rand_tag(a));
      else                     do_write(a, d, rand_tag(a), ($urandom % 8) == 0);
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule